// File: doc/BRIEF.md
# Victim Line Buffer with Deferred Write-Back

This block sits beside a banked, direct-mapped operand cache. Whenever that cache pushes a line out, the line lands here together with its tag and a flag that says whether it holds modified data. The operand fetch logic searches the buffer on every access, in the same cycle as the direct-mapped read. A hit hands the line straight back to the datapath, and the copy held here is dropped.

The buffer also acts as the write queue toward the next-level data cache. Modified lines are offered on that bus only when it is idle and no read is waiting. Once every slot is occupied, the write is offered even with a read waiting. A line whose write is granted becomes clean and stays in the buffer. It is dropped when a lookup takes it or when a new line replaces it. An eviction that arrives while every slot holds a modified line is held off with a ready-low signal.

Top module: `vc_wbuf`

## Requirements
- R1: After reset the buffer is empty: `ev_ready` is 1, `wb_req` is 0 and every lookup misses.
- R2: A line offered with `ev_valid` high while `ev_ready` is high is stored at the clock edge. A later lookup of its tag returns all 128 data bits and the dirty flag it was stored with.
- R3: A lookup is combinational. In the cycle `lk_valid` is high, `lk_hit`, `lk_data` and `lk_dirty` describe the entry whose tag matches `lk_tag`. With no matching entry, `lk_hit` is 0.
- R4: An entry that hits is invalidated at the end of that cycle, so a lookup of the same tag in a later cycle misses.
- R5: A free slot is used first. When all slots are valid, the new line replaces the oldest clean entry, even if a dirty entry is older.
- R6: While all slots are valid and dirty, `ev_ready` is 0 and an offered line is not stored. `ev_ready` returns to 1 in the cycle after a write-back is granted.
- R7: `wb_req` is 1 only if some entry is dirty and `bus_busy` is 0. While any slot is free, `wb_req` is also 0 whenever `rd_pending` is 1.
- R8: While all slots are valid, `rd_pending` does not hold back `wb_req`.
- R9: `wb_tag` and `wb_data` present the oldest dirty entry, so write-backs leave in insertion order.
- R10: A cycle with both `wb_req` and `wb_gnt` high clears that entry's dirty flag. The entry stays valid and a later lookup hits it with `lk_dirty` 0.
- R11: A lookup hit and an eviction in the same cycle are both served. The slot for the new line is chosen from the state before that cycle. If that slot is the one hit, the new line takes the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An evicted line is offered |
| ev_ready | output | 1 | The buffer can accept the offered line this cycle |
| ev_tag | input | 28 | Tag of the evicted line |
| ev_data | input | 128 | Evicted line, one word per bank |
| ev_dirty | input | 1 | The evicted line holds modified data |
| lk_valid | input | 1 | A lookup is made this cycle |
| lk_tag | input | 28 | Tag searched for |
| lk_hit | output | 1 | The searched tag is present |
| lk_data | output | 128 | Line of the matching entry |
| lk_dirty | output | 1 | The matching entry holds modified data |
| bus_busy | input | 1 | The next-level bus is in use |
| rd_pending | input | 1 | A read to the next level is waiting |
| wb_req | output | 1 | A write-back is requested |
| wb_gnt | input | 1 | The requested write-back is taken this cycle |
| wb_tag | output | 28 | Tag of the line being written back |
| wb_data | output | 128 | Line being written back |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a lookup hit and an eviction: the bench fills every slot, then looks up the oldest clean line while offering a new one. It then checks that the new line owns the hit slot, that the old tag misses, and that the other clean line survived. The second pair is a write-back grant and an eviction that is being held off: with all slots dirty, the bench grants the oldest write while offering a line. It expects `ev_ready` to stay low in that cycle and to rise in the next, and the new line must then replace the freshly cleaned entry.

// File: rtl/vcw_pkg.sv
`timescale 1ns/1ps
package vcw_pkg;
   localparam int unsigned VCW_ENTRIES = 8;
   localparam int unsigned VCW_TAG_W   = 28;
   localparam int unsigned VCW_WORD_W  = 32;
   localparam int unsigned VCW_BANKS   = 4;

   // How the slot for an incoming line was found
   typedef enum logic [1:0] {
      PICK_NONE  = 2'd0,
      PICK_FREE  = 2'd1,
      PICK_CLEAN = 2'd2
   } pick_e;
endpackage

// File: rtl/vcw_store.sv
`timescale 1ns/1ps
module vcw_store #(
   parameter int unsigned N    = 8,
   parameter int unsigned TW   = 28,
   parameter int unsigned LW   = 128,
   localparam int unsigned IW  = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_en,
   input  logic [IW-1:0] ins_idx,
   input  logic [TW-1:0] ins_tag,
   input  logic [LW-1:0] ins_data,
   input  logic          ins_dirty,
   input  logic [N-1:0]  inv_vec,
   input  logic [N-1:0]  cln_vec,
   input  logic [TW-1:0] lk_tag,
   output logic [N-1:0]  vld,
   output logic [N-1:0]  drt,
   output logic [N-1:0]  hit_vec,
   output logic [TW-1:0] tag_q  [N],
   output logic [LW-1:0] data_q [N]
);
   for (genvar g = 0; g < N; g++) begin : g_ent
      logic sel;
      assign sel = ins_en && (ins_idx == IW'(g));

      // Insertion wins over a same-cycle invalidation of the slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[g] <= 1'b0;
            drt[g] <= 1'b0;
         end else if (sel) begin
            vld[g] <= 1'b1;
            drt[g] <= ins_dirty;
         end else if (inv_vec[g]) begin
            vld[g] <= 1'b0;
            drt[g] <= 1'b0;
         end else if (cln_vec[g]) begin
            drt[g] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[g]  <= ins_tag;
            data_q[g] <= ins_data;
         end
      end

      assign hit_vec[g] = vld[g] && (tag_q[g] == lk_tag);
   end
endmodule

// File: rtl/vcw_age.sv
`timescale 1ns/1ps
module vcw_age #(
   parameter int unsigned N   = 8,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_en,
   input  logic [IW-1:0] ins_idx,
   input  logic [N-1:0]  clean_mask,
   input  logic [N-1:0]  dirty_mask,
   output logic [N-1:0]  old_clean,
   output logic [N-1:0]  old_dirty
);
   // older_q[i][j] set: slot i was filled before slot j
   logic [N-1:0] older_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               older_q[i][j] <= (i < j);
      end else if (ins_en) begin
         for (int j = 0; j < N; j++) begin
            if (j != int'(ins_idx)) begin
               older_q[ins_idx][j] <= 1'b0;
               older_q[j][ins_idx] <= 1'b1;
            end
         end
      end
   end

   function automatic logic [N-1:0] oldest_of(input logic [N-1:0] m);
      logic [N-1:0] r;
      logic         ok;
      for (int i = 0; i < N; i++) begin
         ok = m[i];
         for (int j = 0; j < N; j++)
            if (j != i && m[j] && !older_q[i][j]) ok = 1'b0;
         r[i] = ok;
      end
      return r;
   endfunction

   always_comb begin
      old_clean = oldest_of(clean_mask);
      old_dirty = oldest_of(dirty_mask);
   end
endmodule

// File: rtl/vcw_wb_arb.sv
`timescale 1ns/1ps
module vcw_wb_arb #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] vld,
   input  logic [N-1:0] drt,
   input  logic [N-1:0] old_dirty,
   input  logic         bus_busy,
   input  logic         rd_pending,
   input  logic         wb_gnt,
   output logic         full,
   output logic         wb_req,
   output logic [N-1:0] cln_vec
);
   logic any_dirty;

   always_comb begin
      full      = &vld;
      any_dirty = |drt;
      // A waiting read goes first unless every slot is taken
      wb_req    = any_dirty && !bus_busy && (full || !rd_pending);
      cln_vec   = (wb_req && wb_gnt) ? old_dirty : '0;
   end
endmodule

// File: rtl/vc_wbuf.sv
`timescale 1ns/1ps
module vc_wbuf #(
   parameter int unsigned ENTRIES = vcw_pkg::VCW_ENTRIES,
   parameter int unsigned TAG_W   = vcw_pkg::VCW_TAG_W,
   parameter int unsigned WORD_W  = vcw_pkg::VCW_WORD_W,
   parameter int unsigned BANKS   = vcw_pkg::VCW_BANKS,
   localparam int unsigned LINE_W = WORD_W * BANKS,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   output logic              ev_ready,
   input  logic [TAG_W-1:0]  ev_tag,
   input  logic [LINE_W-1:0] ev_data,
   input  logic              ev_dirty,
   input  logic              lk_valid,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [LINE_W-1:0] lk_data,
   output logic              lk_dirty,
   input  logic              bus_busy,
   input  logic              rd_pending,
   output logic              wb_req,
   input  logic              wb_gnt,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [LINE_W-1:0] wb_data
);
   import vcw_pkg::*;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("vc_wbuf: ENTRIES must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("vc_wbuf: TAG_W must be positive");
   end
   if (WORD_W < 1 || BANKS < 1) begin : g_bad_line
      $error("vc_wbuf: WORD_W and BANKS must be positive");
   end

   logic [ENTRIES-1:0] vld, drt, hit_vec, inv_vec, cln_vec;
   logic [ENTRIES-1:0] old_clean, old_dirty;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [LINE_W-1:0]  data_q [ENTRIES];
   logic [IDX_W-1:0]   ins_idx;
   logic               ins_en, full;
   pick_e              pick;

   // Slot for an incoming line: lowest free slot, else oldest clean one
   always_comb begin
      pick    = PICK_NONE;
      ins_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld[i]) begin
            pick    = PICK_FREE;
            ins_idx = IDX_W'(i);
         end
      end
      if (pick == PICK_NONE) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (old_clean[i]) begin
               pick    = PICK_CLEAN;
               ins_idx = IDX_W'(i);
            end
         end
      end
   end

   assign ev_ready = (pick != PICK_NONE);
   assign ins_en   = ev_valid && ev_ready;
   assign inv_vec  = lk_valid ? hit_vec : '0;
   assign lk_hit   = lk_valid && (|hit_vec);

   always_comb begin
      lk_data  = '0;
      lk_dirty = 1'b0;
      wb_tag   = '0;
      wb_data  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_data  = lk_data | data_q[i];
            lk_dirty = lk_dirty | drt[i];
         end
         if (old_dirty[i]) begin
            wb_tag  = wb_tag | tag_q[i];
            wb_data = wb_data | data_q[i];
         end
      end
   end

   vcw_store #(.N(ENTRIES), .TW(TAG_W), .LW(LINE_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_en    (ins_en),
      .ins_idx   (ins_idx),
      .ins_tag   (ev_tag),
      .ins_data  (ev_data),
      .ins_dirty (ev_dirty),
      .inv_vec   (inv_vec),
      .cln_vec   (cln_vec),
      .lk_tag    (lk_tag),
      .vld       (vld),
      .drt       (drt),
      .hit_vec   (hit_vec),
      .tag_q     (tag_q),
      .data_q    (data_q)
   );

   vcw_age #(.N(ENTRIES)) u_age (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_en     (ins_en),
      .ins_idx    (ins_idx),
      .clean_mask (vld & ~drt),
      .dirty_mask (vld & drt),
      .old_clean  (old_clean),
      .old_dirty  (old_dirty)
   );

   vcw_wb_arb #(.N(ENTRIES)) u_arb (
      .vld        (vld),
      .drt        (drt),
      .old_dirty  (old_dirty),
      .bus_busy   (bus_busy),
      .rd_pending (rd_pending),
      .wb_gnt     (wb_gnt),
      .full       (full),
      .wb_req     (wb_req),
      .cln_vec    (cln_vec)
   );
endmodule

// File: rtl/vcw_chk.sv
`timescale 1ns/1ps
module vcw_chk #(
   parameter int unsigned N  = 8,
   parameter int unsigned TW = 28
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ev_valid,
   input logic          ev_ready,
   input logic          lk_valid,
   input logic [TW-1:0] lk_tag,
   input logic          lk_hit,
   input logic          bus_busy,
   input logic          rd_pending,
   input logic          wb_req,
   input logic          wb_gnt,
   input logic [TW-1:0] wb_tag,
   input logic [N-1:0]  hit_vec,
   input logic          full
);
   // R3: a tag is held by at most one slot
   a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R4: the same tag cannot hit twice in a row without a refill
   a_r4_hit_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_hit && !ev_valid) |=> !(lk_valid && lk_hit && lk_tag == $past(lk_tag)));

   // R6: ready returns only after a granted write or a hit removal
   a_r6_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_ready) |-> ($past(wb_req && wb_gnt) || $past(lk_hit)));

   // R6: a stall always has a write-back on offer unless the bus is held
   a_r6_stall_drains: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_ready |-> (wb_req || bus_busy));

   // R7: no request on a busy bus
   a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> !bus_busy);

   // R7: a waiting read goes first while a slot is free
   a_r7_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!full && rd_pending) |-> !wb_req);

   // R10: a granted line is not offered again
   a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && wb_gnt && !ev_valid) |=> !(wb_req && wb_tag == $past(wb_tag)));
endmodule

bind vc_wbuf vcw_chk #(.N(ENTRIES), .TW(TAG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_valid   (ev_valid),
   .ev_ready   (ev_ready),
   .lk_valid   (lk_valid),
   .lk_tag     (lk_tag),
   .lk_hit     (lk_hit),
   .bus_busy   (bus_busy),
   .rd_pending (rd_pending),
   .wb_req     (wb_req),
   .wb_gnt     (wb_gnt),
   .wb_tag     (wb_tag),
   .hit_vec    (hit_vec),
   .full       (full)
);

// File: tb/sim_vc_wbuf.sv
`timescale 1ns/1ps
module sim_vc_wbuf;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ev_valid = 1'b0, ev_dirty = 1'b0;
   logic [27:0]  ev_tag = '0;
   logic [127:0] ev_data = '0;
   logic         lk_valid = 1'b0;
   logic [27:0]  lk_tag = '0;
   logic         bus_busy = 1'b0, rd_pending = 1'b0, wb_gnt = 1'b0;
   logic         ev_ready, lk_hit, lk_dirty, wb_req;
   logic [127:0] lk_data, wb_data;
   logic [27:0]  wb_tag;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;
   logic [27:0] exp_q[$];

   always #10 clk = ~clk;

   vc_wbuf u0 (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_tag(ev_tag),
      .ev_data(ev_data), .ev_dirty(ev_dirty),
      .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_hit(lk_hit),
      .lk_data(lk_data), .lk_dirty(lk_dirty),
      .bus_busy(bus_busy), .rd_pending(rd_pending),
      .wb_req(wb_req), .wb_gnt(wb_gnt), .wb_tag(wb_tag), .wb_data(wb_data)
   );

   function automatic logic [127:0] mk(input logic [27:0] t);
      return {t, 4'h1, t, 4'h2, t, 4'h3, t, 4'h4};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic evict(input logic [27:0] t, input logic d);
      ev_valid = 1'b1; ev_tag = t; ev_data = mk(t); ev_dirty = d;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic look(input logic [27:0] t, input logic eh, input logic ed, input string req);
      lk_valid = 1'b1; lk_tag = t;
      #1;
      chk(lk_hit === eh, req, "lk_hit", 128'(lk_hit), 128'(eh));
      if (eh) begin
         chk(lk_data === mk(t), req, "lk_data", lk_data, mk(t));
         chk(lk_dirty === ed, req, "lk_dirty", 128'(lk_dirty), 128'(ed));
      end
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic expect_wb(input logic [27:0] t);
      exp_q.push_back(t);
   endtask

   task automatic grant1();
      wb_gnt = 1'b1;
      @(negedge clk);
      wb_gnt = 1'b0;
   endtask

   // Monitor: every accepted write-back must match the queue head (R9, R10)
   initial begin
      forever begin
         @(negedge clk);
         #8;
         if (rst_n && wb_req && wb_gnt) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected write-back tag", 128'(wb_tag), 128'(0));
            end else begin
               logic [27:0] e;
               e = exp_q.pop_front();
               chk(wb_tag === e, "R9", "write-back tag", 128'(wb_tag), 128'(e));
               chk(wb_data === mk(e), "R9", "write-back data", wb_data, mk(e));
            end
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty after reset
      chk(ev_ready === 1'b1, "R1", "ev_ready", 128'(ev_ready), 128'(1));
      chk(wb_req === 1'b0, "R1", "wb_req", 128'(wb_req), 128'(0));
      @(negedge clk);
      look(28'h0000100, 1'b0, 1'b0, "R1");

      // R2, R3, R4: store, combinational hit, drop on hit
      evict(28'h0000100, 1'b0);
      look(28'h0BADBAD, 1'b0, 1'b0, "R3");
      look(28'h0000100, 1'b1, 1'b0, "R2");
      look(28'h0000100, 1'b0, 1'b0, "R4");
      bus_busy = 1'b1;
      evict(28'h0000111, 1'b1);
      look(28'h0000111, 1'b1, 1'b1, "R2");

      // R7, R9, R10: deferred write-back
      evict(28'h0000201, 1'b1);
      evict(28'h0000202, 1'b1);
      evict(28'h0000203, 1'b0);
      #1;
      chk(wb_req === 1'b0, "R7", "wb_req with bus busy", 128'(wb_req), 128'(0));
      bus_busy = 1'b0; rd_pending = 1'b1;
      #1;
      chk(wb_req === 1'b0, "R7", "wb_req with read waiting", 128'(wb_req), 128'(0));
      rd_pending = 1'b0;
      #1;
      chk(wb_req === 1'b1, "R7", "wb_req on idle bus", 128'(wb_req), 128'(1));
      chk(wb_tag === 28'h0000201, "R9", "oldest dirty first", 128'(wb_tag), 128'(28'h0000201));
      expect_wb(28'h0000201);
      grant1();
      expect_wb(28'h0000202);
      grant1();
      #1;
      chk(wb_req === 1'b0, "R10", "wb_req after all written", 128'(wb_req), 128'(0));
      @(negedge clk);
      look(28'h0000201, 1'b1, 1'b0, "R10");
      look(28'h0000202, 1'b1, 1'b0, "R10");
      look(28'h0000203, 1'b1, 1'b0, "R2");

      // R5, R8, R11: full buffer
      bus_busy = 1'b1;
      evict(28'h0000300, 1'b0);
      evict(28'h0000301, 1'b1);
      evict(28'h0000302, 1'b0);
      for (int i = 3; i < 8; i++) evict(28'h0000300 + 28'(i), 1'b1);
      #1;
      chk(ev_ready === 1'b1, "R5", "ready with clean entries", 128'(ev_ready), 128'(1));
      bus_busy = 1'b0; rd_pending = 1'b1;
      #1;
      chk(wb_req === 1'b1, "R8", "write beats read when full", 128'(wb_req), 128'(1));
      chk(wb_tag === 28'h0000301, "R8", "full write tag", 128'(wb_tag), 128'(28'h0000301));
      bus_busy = 1'b1; rd_pending = 1'b0;
      @(negedge clk);
      evict(28'h0000400, 1'b0);
      look(28'h0000300, 1'b0, 1'b0, "R5");
      // hit on oldest clean entry while a new line arrives
      lk_valid = 1'b1; lk_tag = 28'h0000302;
      ev_valid = 1'b1; ev_tag = 28'h0000401; ev_data = mk(28'h0000401); ev_dirty = 1'b0;
      #1;
      chk(lk_hit === 1'b1, "R11", "hit during eviction", 128'(lk_hit), 128'(1));
      chk(lk_data === mk(28'h0000302), "R11", "hit data", lk_data, mk(28'h0000302));
      chk(ev_ready === 1'b1, "R11", "ready during hit", 128'(ev_ready), 128'(1));
      @(negedge clk);
      lk_valid = 1'b0; ev_valid = 1'b0;
      look(28'h0000302, 1'b0, 1'b0, "R11");
      look(28'h0000401, 1'b1, 1'b0, "R11");
      look(28'h0000400, 1'b1, 1'b0, "R5");
      bus_busy = 1'b0;
      expect_wb(28'h0000301);
      for (int i = 3; i < 8; i++) expect_wb(28'h0000300 + 28'(i));
      for (int i = 0; i < 6; i++) grant1();
      #1;
      chk(wb_req === 1'b0, "R9", "queue drained", 128'(wb_req), 128'(0));

      // R6: all dirty stalls eviction
      do_reset();
      bus_busy = 1'b1;
      for (int i = 0; i < 8; i++) evict(28'h0000500 + 28'(i), 1'b1);
      #1;
      chk(ev_ready === 1'b0, "R6", "ready when all dirty", 128'(ev_ready), 128'(0));
      ev_valid = 1'b1; ev_tag = 28'h0000600; ev_data = mk(28'h0000600); ev_dirty = 1'b1;
      @(negedge clk);
      ev_valid = 1'b0;
      look(28'h0000600, 1'b0, 1'b0, "R6");
      bus_busy = 1'b0;
      expect_wb(28'h0000500);
      wb_gnt = 1'b1;
      ev_valid = 1'b1; ev_tag = 28'h0000600; ev_data = mk(28'h0000600); ev_dirty = 1'b1;
      #1;
      chk(ev_ready === 1'b0, "R6", "ready in grant cycle", 128'(ev_ready), 128'(0));
      chk(wb_req === 1'b1, "R6", "write offered while stalled", 128'(wb_req), 128'(1));
      @(negedge clk);
      wb_gnt = 1'b0; bus_busy = 1'b1;
      #1;
      chk(ev_ready === 1'b1, "R6", "ready after write", 128'(ev_ready), 128'(1));
      @(negedge clk);
      ev_valid = 1'b0;
      look(28'h0000500, 1'b0, 1'b0, "R6");
      look(28'h0000600, 1'b1, 1'b1, "R6");
      look(28'h0000501, 1'b1, 1'b1, "R6");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R9", "pending expected writes", 128'(exp_q.size()), 128'(0));
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule